// File: doc/BRIEF.md
# DRAM Command Generator with Timing Checker

This block sits behind a memory request scheduler and turns one scheduled access at a time into the command stream a DRAM device needs. An access gives a bank, a row, a column and a read/write flag. The generator keeps track of which banks are open and which row each one holds. From that it decides whether the access can go straight to a column command, needs a row opened first, or needs the current row closed before a new one is opened. Each READ or WRITE moves one burst of 8 words. The data path itself is outside the block.

Every command waits until all minimum spacing rules that apply to it are met. Some rules hold per bank: activate to column, activate to precharge, precharge to activate, and write to precharge. Others hold across banks: column to column, write to read, at most four activates in a rolling window, and the quiet period after a refresh. A configuration input picks the page policy. Under close-page each access ends with a precharge of its bank. Under open-page the row stays open for later hits. A refresh request closes every open bank and then issues REFRESH.

Top module: `dram_cmd_gen`

## Requirements
- R1: `cmdOut` has at most one bit set in any cycle, and all zeros means NOP. The bit positions are: bit 0 ACTIVATE, bit 1 READ, bit 2 WRITE, bit 3 PRECHARGE, bit 4 REFRESH. After reset `cmdOut` is 0, `doneOut` is 0 and `reqReady` is 1.
- R2: An access to a bank whose open row equals the requested row issues only the column command (READ or WRITE), with `cmdAddr` equal to the column.
- R3: An access to a closed bank issues ACTIVATE and then the column command. An access to a bank holding a different row issues PRECHARGE, then ACTIVATE, then the column command. On ACTIVATE `cmdAddr` carries the row. Every command of an access carries its bank on `cmdBank`.
- R4: A READ or WRITE comes no sooner than T_RCD cycles after the ACTIVATE of its bank.
- R5: PRECHARGE of a bank comes no sooner than T_RAS cycles after its ACTIVATE. ACTIVATE of a bank comes no sooner than T_RP cycles after its PRECHARGE, so two ACTIVATEs to one bank are at least T_RAS+T_RP apart.
- R6: Any ACTIVATE comes at least T_FAW cycles after the fourth-latest earlier ACTIVATE.
- R7: Column commands are at least T_CCD cycles apart. A READ comes at least T_WTR cycles after the last WRITE. PRECHARGE of a bank comes at least T_WR cycles after the last WRITE to that bank.
- R8: `closePage` is sampled when an access is accepted. If it was 1, a PRECHARGE of the bank follows the column command and `doneOut` pulses with that PRECHARGE. If it was 0, the row stays open and `doneOut` pulses with the column command.
- R9: While `refReq` is high and no access is in progress, the open banks are precharged in ascending bank order. REFRESH is then issued with all banks closed, and no command follows it for T_RFC cycles.
- R10: An access is taken only on a cycle with `reqValid` and `reqReady` both high. `reqReady` is low while an access is in progress and while `refReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| closePage | input | 1 | Page policy: 1 close-page, 0 open-page |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Generator can take an access this cycle |
| reqBank | input | BANK_W | Bank of the access |
| reqRow | input | ROW_W | Row of the access |
| reqCol | input | COL_W | Column of the access |
| reqWrite | input | 1 | 1 write, 0 read |
| refReq | input | 1 | Refresh wanted, held until REFRESH appears |
| cmdOut | output | 5 | One-hot command strobe |
| cmdBank | output | BANK_W | Bank of the command |
| cmdAddr | output | ADDR_W | Row for ACTIVATE, column for READ/WRITE, else 0 |
| doneOut | output | 1 | Pulses with the last command of an access |

## Verification
The hardest case to reach from the ports is the four-activate window actually holding back an ACTIVATE. Only one access is in flight at a time, and each ACTIVATE is followed by a column command, so with short windows the activates are spaced too far apart to crowd it. The bench therefore uses a window wider than four back-to-back activate-to-read turns. It clears every bank with a refresh and then sends five open-page reads to five fresh banks. It expects the fifth ACTIVATE exactly one window after the first. The write-to-read and write-to-precharge spacings are also widened so that they bind, and are timed exactly. A monitor then checks every spacing rule on every command during a long random mix of hits, misses, both policies and refreshes.

// File: rtl/cmdgen_pkg.sv
package cmdgen_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SERVE,
    S_CLOSE,
    S_REFR
  } ctlState_t;

  // Issue strobes from control to datapath; at most one set per cycle.
  typedef struct packed {
    logic rfsh;
    logic pre;
    logic wr;
    logic rd;
    logic act;
  } cmdStrobe_t;

  // Legality and bank status for the queried bank.
  typedef struct packed {
    logic bankOpen;
    logic rowHit;
    logic canAct;
    logic canRd;
    logic canWr;
    logic canPre;
    logic canRef;
    logic anyOpen;
  } bankStatus_t;

  localparam int CMD_W = 5;

endpackage

// File: rtl/cmdgen_datapath.sv
module cmdgen_datapath
  import cmdgen_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int T_RCD     = 5,
  parameter int T_RAS     = 14,
  parameter int T_RP      = 5,
  parameter int T_FAW     = 16,
  parameter int T_CCD     = 4,
  parameter int T_WTR     = 4,
  parameter int T_WR      = 6,
  parameter int T_RFC     = 20,
  parameter int ACT_LIMIT = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic [BANK_W-1:0] issueBank,
  input  logic [ADDR_W-1:0] issueAddr,
  input  logic [BANK_W-1:0] queryBank,
  input  logic [ROW_W-1:0]  queryRow,
  output bankStatus_t       status,
  output logic [BANK_W-1:0] firstOpen,
  output logic [CMD_W-1:0]  cmdOut,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr
);

  localparam int TW    = $clog2(T_FAW + T_RFC + T_RAS + T_RP + T_WR + 2);
  localparam int SEL_W = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1;

  logic [NUM_BANKS-1:0] bankOpen;
  logic [ROW_W-1:0]     openRow [NUM_BANKS];
  logic [TW-1:0]        rcdCnt  [NUM_BANKS];
  logic [TW-1:0]        rasCnt  [NUM_BANKS];
  logic [TW-1:0]        rpCnt   [NUM_BANKS];
  logic [TW-1:0]        wrCnt   [NUM_BANKS];
  logic [TW-1:0]        ccdCnt, wtrCnt, rfcCnt;
  logic [TW-1:0]        fawCnt  [ACT_LIMIT];
  logic [SEL_W-1:0]     fawSel;
  logic                 fawFree;
  logic                 rpAllDone;
  logic                 quiet;

  // Per-bank state and timers
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hitBank;
    assign hitBank = (issueBank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankOpen[b] <= 1'b0;
        openRow[b]  <= '0;
        rcdCnt[b]   <= '0;
        rasCnt[b]   <= '0;
        rpCnt[b]    <= '0;
        wrCnt[b]    <= '0;
      end else begin
        if (strobe.act && hitBank) begin
          bankOpen[b] <= 1'b1;
          openRow[b]  <= issueAddr[ROW_W-1:0];
          rcdCnt[b]   <= TW'(T_RCD - 1);
          rasCnt[b]   <= TW'(T_RAS - 1);
        end else begin
          if (rcdCnt[b] != '0) rcdCnt[b] <= rcdCnt[b] - TW'(1);
          if (rasCnt[b] != '0) rasCnt[b] <= rasCnt[b] - TW'(1);
        end
        if (strobe.pre && hitBank) begin
          bankOpen[b] <= 1'b0;
          rpCnt[b]    <= TW'(T_RP - 1);
        end else if (rpCnt[b] != '0) begin
          rpCnt[b] <= rpCnt[b] - TW'(1);
        end
        if (strobe.wr && hitBank) begin
          wrCnt[b] <= TW'(T_WR - 1);
        end else if (wrCnt[b] != '0) begin
          wrCnt[b] <= wrCnt[b] - TW'(1);
        end
      end
    end
  end

  // Shared column, turnaround and refresh timers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccdCnt <= '0;
      wtrCnt <= '0;
      rfcCnt <= '0;
    end else begin
      if (strobe.rd || strobe.wr) ccdCnt <= TW'(T_CCD - 1);
      else if (ccdCnt != '0)      ccdCnt <= ccdCnt - TW'(1);
      if (strobe.wr)              wtrCnt <= TW'(T_WTR - 1);
      else if (wtrCnt != '0)      wtrCnt <= wtrCnt - TW'(1);
      if (strobe.rfsh)            rfcCnt <= TW'(T_RFC - 1);
      else if (rfcCnt != '0)      rfcCnt <= rfcCnt - TW'(1);
    end
  end

  // Rolling activate window: one slot per activate still inside the window
  always_comb begin
    fawFree = 1'b0;
    fawSel  = '0;
    for (int i = ACT_LIMIT - 1; i >= 0; i--) begin
      if (fawCnt[i] == '0) begin
        fawFree = 1'b1;
        fawSel  = SEL_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ACT_LIMIT; i++) fawCnt[i] <= '0;
    end else begin
      for (int i = 0; i < ACT_LIMIT; i++) begin
        if (strobe.act && fawSel == SEL_W'(i)) fawCnt[i] <= TW'(T_FAW - 1);
        else if (fawCnt[i] != '0)              fawCnt[i] <= fawCnt[i] - TW'(1);
      end
    end
  end

  // Bank summary
  always_comb begin
    firstOpen = '0;
    rpAllDone = 1'b1;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bankOpen[b]) firstOpen = BANK_W'(b);
      if (rpCnt[b] != '0) rpAllDone = 1'b0;
    end
  end

  assign quiet = (rfcCnt == '0);

  always_comb begin
    status.bankOpen = bankOpen[queryBank];
    status.rowHit   = bankOpen[queryBank] && (openRow[queryBank] == queryRow);
    status.canAct   = quiet && !bankOpen[queryBank] && (rpCnt[queryBank] == '0) && fawFree;
    status.canWr    = quiet && bankOpen[queryBank] && (rcdCnt[queryBank] == '0) && (ccdCnt == '0);
    status.canRd    = status.canWr && (wtrCnt == '0);
    status.canPre   = quiet && bankOpen[queryBank] && (rasCnt[queryBank] == '0) && (wrCnt[queryBank] == '0);
    status.canRef   = quiet && (bankOpen == '0) && rpAllDone;
    status.anyOpen  = (bankOpen != '0);
  end

  // Registered command outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdOut  <= '0;
      cmdBank <= '0;
      cmdAddr <= '0;
    end else begin
      cmdOut  <= {strobe.rfsh, strobe.pre, strobe.wr, strobe.rd, strobe.act};
      cmdBank <= (strobe != '0) ? issueBank : '0;
      cmdAddr <= (strobe.act || strobe.rd || strobe.wr) ? issueAddr : '0;
    end
  end

  // R1: never two commands in one cycle
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdOut));

  // R2: a column command always lands on an open bank
  a_r2_col_open: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut[1] || cmdOut[2]) |-> bankOpen[cmdBank]);

  // R3: ACTIVATE leaves its bank open on the row it carried
  a_r3_act_row: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut[0] |-> (bankOpen[cmdBank] && openRow[cmdBank] == cmdAddr[ROW_W-1:0]));

  // R9: REFRESH only with every bank closed
  a_r9_ref_closed: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut[4] |-> (bankOpen == '0));

  // R4: column command never right behind the ACTIVATE of its bank
  if (T_RCD > 1) begin : g_rcdChk
    a_r4_rcd_gap: assert property (@(posedge clk) disable iff (!rstN)
      (cmdOut[1] || cmdOut[2]) |-> !($past(cmdOut[0]) && $past(cmdBank) == cmdBank));
  end

endmodule

// File: rtl/cmdgen_control.sv
module cmdgen_control
  import cmdgen_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              closePage,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqWrite,
  input  logic              refReq,
  output logic              reqReady,
  input  bankStatus_t       status,
  input  logic [BANK_W-1:0] firstOpen,
  output cmdStrobe_t        strobe,
  output logic [BANK_W-1:0] issueBank,
  output logic [ADDR_W-1:0] issueAddr,
  output logic [BANK_W-1:0] queryBank,
  output logic [ROW_W-1:0]  queryRow,
  output logic              doneOut
);

  ctlState_t         state, nextState;
  logic [BANK_W-1:0] curBank;
  logic [ROW_W-1:0]  curRow;
  logic [COL_W-1:0]  curCol;
  logic              curWrite, curClose;
  logic              doneNext, accept, colGo;

  assign reqReady = (state == S_IDLE) && !refReq;
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      doneOut  <= 1'b0;
      curBank  <= '0;
      curRow   <= '0;
      curCol   <= '0;
      curWrite <= 1'b0;
      curClose <= 1'b0;
    end else begin
      state   <= nextState;
      doneOut <= doneNext;
      if (accept) begin
        curBank  <= reqBank;
        curRow   <= reqRow;
        curCol   <= reqCol;
        curWrite <= reqWrite;
        curClose <= closePage;
      end
    end
  end

  assign colGo = curWrite ? status.canWr : status.canRd;

  always_comb begin
    strobe    = '0;
    nextState = state;
    doneNext  = 1'b0;
    issueBank = curBank;
    issueAddr = '0;
    queryBank = (state == S_REFR) ? firstOpen : curBank;
    queryRow  = curRow;
    unique case (state)
      S_IDLE: begin
        if (refReq)        nextState = S_REFR;
        else if (reqValid) nextState = S_SERVE;
      end
      S_SERVE: begin
        if (status.rowHit) begin
          if (colGo) begin
            strobe.wr = curWrite;
            strobe.rd = !curWrite;
            issueAddr = ADDR_W'(curCol);
            nextState = curClose ? S_CLOSE : S_IDLE;
            doneNext  = !curClose;
          end
        end else if (status.bankOpen) begin
          strobe.pre = status.canPre;
        end else if (status.canAct) begin
          strobe.act = 1'b1;
          issueAddr  = ADDR_W'(curRow);
        end
      end
      S_CLOSE: begin
        if (status.canPre) begin
          strobe.pre = 1'b1;
          doneNext   = 1'b1;
          nextState  = S_IDLE;
        end
      end
      S_REFR: begin
        issueBank = firstOpen;
        if (status.anyOpen) begin
          strobe.pre = status.canPre;
        end else if (status.canRef) begin
          strobe.rfsh = 1'b1;
          nextState   = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R10: once an access is taken the generator is busy on the next cycle
  a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);

  // R8: the closing precharge is only issued for an access taken under close-page
  a_r8_close_policy: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CLOSE) |-> curClose);

endmodule

// File: rtl/dram_cmd_gen.sv
module dram_cmd_gen
  import cmdgen_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int T_RCD     = 5,
  parameter int T_RAS     = 14,
  parameter int T_RP      = 5,
  parameter int T_FAW     = 16,
  parameter int T_CCD     = 4,
  parameter int T_WTR     = 4,
  parameter int T_WR      = 6,
  parameter int T_RFC     = 20,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              closePage,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqWrite,
  input  logic              refReq,
  output logic [4:0]        cmdOut,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic              doneOut
);

  cmdStrobe_t        strobe;
  bankStatus_t       status;
  logic [BANK_W-1:0] issueBank, queryBank, firstOpen;
  logic [ADDR_W-1:0] issueAddr;
  logic [ROW_W-1:0]  queryRow;

  cmdgen_control #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .closePage(closePage),
    .reqValid(reqValid), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWrite(reqWrite), .refReq(refReq), .reqReady(reqReady),
    .status(status), .firstOpen(firstOpen), .strobe(strobe),
    .issueBank(issueBank), .issueAddr(issueAddr),
    .queryBank(queryBank), .queryRow(queryRow), .doneOut(doneOut)
  );

  cmdgen_datapath #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_FAW(T_FAW),
    .T_CCD(T_CCD), .T_WTR(T_WTR), .T_WR(T_WR), .T_RFC(T_RFC), .ACT_LIMIT(4)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issueBank(issueBank), .issueAddr(issueAddr),
    .queryBank(queryBank), .queryRow(queryRow),
    .status(status), .firstOpen(firstOpen),
    .cmdOut(cmdOut), .cmdBank(cmdBank), .cmdAddr(cmdAddr)
  );

  // R8: done only ever rides on a column command or a precharge
  a_r8_done_with_cmd: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (cmdOut[1] || cmdOut[2] || cmdOut[3]));

endmodule

// File: tb/dram_cmd_gen_tb.sv
module dram_cmd_gen_tb_top;

  localparam int NB = 8, RW = 13, CW = 10, BW = 3, AW = 13;
  localparam int T_RCD = 5, T_RAS = 14, T_RP = 5, T_FAW = 48;
  localparam int T_CCD = 4, T_WTR = 10, T_WR = 12, T_RFC = 20;
  localparam int C_ACT = 1, C_RD = 2, C_WR = 4, C_PRE = 8, C_REF = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic closePage = 1'b0, reqValid = 1'b0, reqWrite = 1'b0, refReq = 1'b0;
  logic [BW-1:0] reqBank = '0;
  logic [RW-1:0] reqRow = '0;
  logic [CW-1:0] reqCol = '0;
  logic reqReady, doneOut;
  logic [4:0] cmdOut;
  logic [BW-1:0] cmdBank;
  logic [AW-1:0] cmdAddr;

  always #4 clk = ~clk;

  dram_cmd_gen #(
    .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_FAW(T_FAW),
    .T_CCD(T_CCD), .T_WTR(T_WTR), .T_WR(T_WR), .T_RFC(T_RFC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .closePage(closePage), .reqValid(reqValid),
    .reqReady(reqReady), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWrite(reqWrite), .refReq(refReq), .cmdOut(cmdOut), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .doneOut(doneOut)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit mOpen [NB];
  int mRow [NB];
  int lastAct [NB], lastPre [NB], lastWrB [NB];
  int lastCol = -1000, lastWr = -1000, lastRd = -1000, lastRef = -1000;
  int actHist [5];
  int obsN = 0, doneCnt = 0;
  int obsCmd [8], obsBank [8], obsAddr [8], obsDone [8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: spacing rules on every command and a log for sequence checks
  always @(negedge clk) begin
    if (rstN) begin
      if (doneOut) doneCnt++;
      if (cmdOut != 0) begin
        automatic int b = int'(cmdBank);
        chk($countones(cmdOut) == 1, "R1 one-hot", int'(cmdOut), 1);
        chk(cyc - lastRef >= T_RFC, "R9 quiet after refresh", cyc - lastRef, T_RFC);
        if (cmdOut == 5'(C_ACT)) begin
          chk(!mOpen[b], "R3 activate on closed bank", int'(mOpen[b]), 0);
          chk(cyc - lastPre[b] >= T_RP, "R5 precharge to activate", cyc - lastPre[b], T_RP);
          chk(cyc - lastAct[b] >= T_RAS + T_RP, "R5 activate cycle", cyc - lastAct[b], T_RAS + T_RP);
          chk(cyc - actHist[3] >= T_FAW, "R6 four-activate window", cyc - actHist[3], T_FAW);
          for (int i = 4; i > 0; i--) actHist[i] = actHist[i-1];
          actHist[0] = cyc;
          lastAct[b] = cyc;
          mOpen[b] = 1'b1;
          mRow[b] = int'(cmdAddr);
        end
        if (cmdOut == 5'(C_RD) || cmdOut == 5'(C_WR)) begin
          chk(mOpen[b], "R2 column on open bank", int'(mOpen[b]), 1);
          chk(cyc - lastAct[b] >= T_RCD, "R4 activate to column", cyc - lastAct[b], T_RCD);
          chk(cyc - lastCol >= T_CCD, "R7 column spacing", cyc - lastCol, T_CCD);
          if (cmdOut == 5'(C_RD)) begin
            chk(cyc - lastWr >= T_WTR, "R7 write to read", cyc - lastWr, T_WTR);
            lastRd = cyc;
          end else begin
            lastWr = cyc;
            lastWrB[b] = cyc;
          end
          lastCol = cyc;
        end
        if (cmdOut == 5'(C_PRE)) begin
          chk(mOpen[b], "R3 precharge on open bank", int'(mOpen[b]), 1);
          chk(cyc - lastAct[b] >= T_RAS, "R5 activate to precharge", cyc - lastAct[b], T_RAS);
          chk(cyc - lastWrB[b] >= T_WR, "R7 write to precharge", cyc - lastWrB[b], T_WR);
          mOpen[b] = 1'b0;
          lastPre[b] = cyc;
        end
        if (cmdOut == 5'(C_REF)) begin
          automatic int openCnt = 0;
          for (int k = 0; k < NB; k++) if (mOpen[k]) openCnt++;
          chk(openCnt == 0, "R9 refresh with banks closed", openCnt, 0);
          lastRef = cyc;
        end
        if (obsN < 8) begin
          obsCmd[obsN] = int'(cmdOut);
          obsBank[obsN] = b;
          obsAddr[obsN] = int'(cmdAddr);
          obsDone[obsN] = int'(doneOut);
          obsN++;
        end
      end else begin
        chk(!doneOut, "R8 done without command", int'(doneOut), 0);
      end
    end
  end

  // Expected sequence bookkeeping
  int eN;
  int eCmd [8], eBank [8], eAddr [8];

  function automatic void pushExp(input int c, input int b, input int a);
    eCmd[eN] = c; eBank[eN] = b; eAddr[eN] = a; eN++;
  endfunction

  task automatic compareLog(input string tag, input bit doneLast);
    chk(obsN == eN, {tag, " command count"}, obsN, eN);
    for (int i = 0; i < eN && i < obsN; i++) begin
      chk(obsCmd[i] == eCmd[i], {tag, " command kind"}, obsCmd[i], eCmd[i]);
      chk(obsBank[i] == eBank[i], {tag, " command bank"}, obsBank[i], eBank[i]);
      chk(obsAddr[i] == eAddr[i], {tag, " command address"}, obsAddr[i], eAddr[i]);
      if (doneLast)
        chk(obsDone[i] == int'(i == eN - 1), "R8 done placement", obsDone[i], int'(i == eN - 1));
    end
  endtask

  task automatic doReq(input int b, input int row, input int col, input bit wr, input bit cp);
    string tag;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    eN = 0;
    if (mOpen[b] && mRow[b] == row) begin
      tag = "R2 row hit";
    end else begin
      tag = "R3 row miss";
      if (mOpen[b]) pushExp(C_PRE, b, 0);
      pushExp(C_ACT, b, row);
    end
    pushExp(wr ? C_WR : C_RD, b, col);
    if (cp) pushExp(C_PRE, b, 0);
    if (cp) tag = {tag, " R8 close-page"};
    obsN = 0;
    reqBank = BW'(b); reqRow = RW'(row); reqCol = CW'(col);
    reqWrite = wr; closePage = cp; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneOut) @(negedge clk);
    @(posedge clk);
    compareLog(tag, 1'b1);
  endtask

  task automatic doRef();
    @(negedge clk);
    eN = 0;
    for (int k = 0; k < NB; k++) if (mOpen[k]) pushExp(C_PRE, k, 0);
    pushExp(C_REF, 0, 0);
    obsN = 0;
    refReq = 1'b1;
    while (cmdOut != 5'(C_REF)) @(negedge clk);
    refReq = 1'b0;
    @(posedge clk);
    compareLog("R9 refresh sequence", 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0, dc;
    void'($urandom(32'd20240611));
    for (int k = 0; k < NB; k++) begin
      mOpen[k] = 1'b0; mRow[k] = 0;
      lastAct[k] = -1000; lastPre[k] = -1000; lastWrB[k] = -1000;
    end
    for (int i = 0; i < 5; i++) actHist[i] = -1000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmdOut == 0, "R1 reset NOP", int'(cmdOut), 0);
    chk(doneOut == 0, "R1 reset done low", int'(doneOut), 0);
    chk(reqReady == 1, "R1 reset ready high", int'(reqReady), 1);
    rstN = 1'b1;

    doRef();
    doReq(0, 7, 3, 1'b0, 1'b0);
    chk(lastRd - lastAct[0] == T_RCD, "R4 exact activate to read", lastRd - lastAct[0], T_RCD);
    doReq(0, 7, 9, 1'b1, 1'b0);
    doReq(0, 7, 11, 1'b0, 1'b0);
    chk(lastRd - lastWr == T_WTR, "R7 exact write to read", lastRd - lastWr, T_WTR);
    doReq(0, 7, 12, 1'b1, 1'b1);
    chk(lastPre[0] - lastWr == T_WR, "R7 exact write to precharge", lastPre[0] - lastWr, T_WR);
    doReq(1, 3, 0, 1'b0, 1'b1);
    chk(lastPre[1] - lastAct[1] == T_RAS, "R5 exact activate to precharge", lastPre[1] - lastAct[1], T_RAS);
    doReq(2, 4, 1, 1'b0, 1'b0);
    t0 = lastAct[2];
    doReq(2, 6, 2, 1'b0, 1'b0);
    chk(lastAct[2] - lastPre[2] == T_RP, "R5 exact precharge to activate", lastAct[2] - lastPre[2], T_RP);
    chk(lastAct[2] - t0 == T_RAS + T_RP, "R5 exact activate cycle", lastAct[2] - t0, T_RAS + T_RP);

    // Four-activate window made to bind
    doRef();
    for (int b = 3; b < 8; b++) doReq(b, 100 + b, b, 1'b0, 1'b0);
    chk(actHist[0] - actHist[4] == T_FAW, "R6 fifth activate held to window", actHist[0] - actHist[4], T_FAW);

    // Request presented together with refresh is not taken
    @(negedge clk);
    eN = 0;
    for (int k = 0; k < NB; k++) if (mOpen[k]) pushExp(C_PRE, k, 0);
    pushExp(C_REF, 0, 0);
    obsN = 0; dc = doneCnt;
    refReq = 1'b1; reqValid = 1'b1; reqBank = 3'd1; reqRow = 13'd9; reqWrite = 1'b0;
    @(negedge clk);
    chk(reqReady == 0, "R10 not ready during refresh", int'(reqReady), 0);
    while (cmdOut != 5'(C_REF)) @(negedge clk);
    refReq = 1'b0; reqValid = 1'b0;
    repeat (40) @(negedge clk);
    compareLog("R10 request ignored under refresh", 1'b0);
    chk(doneCnt == dc, "R10 no access completed", doneCnt - dc, 0);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(19) == 0) doRef();
      else doReq(int'($urandom_range(NB - 1)), int'($urandom_range(3)),
                 int'($urandom_range(1023)), 1'($urandom_range(1)), 1'($urandom_range(1)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule